// File: doc/BRIEF.md
# UART Receive FIFO with Status Flags

This block is the receive half of a fast 8N1 serial port. A 16x oversampling sampler, paced by a separate baud-tick input, turns the incoming line into bytes. Each byte goes into a 64-entry FIFO together with two status bits: framing error and break. Reading the data port pops the oldest entry. The read returns an 11-bit word that holds the byte, an empty indication and the two status bits.

The block reports the fill level and raises a trigger request when the level reaches a threshold picked by a 3-bit code. It raises a timeout request when data sits in the FIFO and the line has stayed quiet for a selected number of character times. It pulses an overrun indication when a byte completes while the FIFO is full. Turning these requests into interrupts, and the bus access, belong to the surrounding logic.

Top module: `uart_rx_fifo`

## Requirements
- R1: While the FIFO holds data, `rd_word` shows the oldest entry: the byte in bits 7:0 (first serial bit in bit 0), bit 8 = 0, bit 9 = framing error, bit 10 = break. A one-cycle `rd_en` pops the entry. Entries come out in arrival order.
- R2: While the FIFO is empty, `rd_word` is 11'h100: bit 8 = 1 and all other bits 0. A read while empty leaves the level at 0.
- R3: A frame whose stop bit samples low and whose data is non-zero is stored with bit 9 = 1 and bit 10 = 0.
- R4: A frame with all-zero data and a low stop bit is a break. It is stored once, as 11'h400 (bit 10 = 1, bit 9 = 0, byte 0). No further frame starts until the line returns high.
- R5: `level` equals the number of stored entries, from 0 to 64. It rises one cycle after a stop-bit sample and falls one cycle after a read of a non-empty FIFO.
- R6: `trig_req` is high exactly while `level` >= threshold. The threshold codes on `trig_sel` are 0→1, 1→4, 2→8, 3→16, 4→32, and 5, 6 or 7→48.
- R7: `tmo_sel` code 0 disables the timeout. Codes 1, 2 and 3 raise `tmo_req` after 4, 8 or 16 character times (one character time is 160 baud ticks) in which the FIFO is non-empty, the receiver is idle, and no push or pop occurs. `tmo_req` is never high while the FIFO is empty.
- R8: A read of a non-empty FIFO, or a start bit or byte arrival, drops `tmo_req` by the next cycle and restarts the count.
- R9: A byte that completes while the FIFO is full and no pop occurs in that cycle gives a single-cycle `overrun` pulse. The byte is discarded, and the 64 stored entries and their order are kept.
- R10: After reset, `level` = 0, `rd_word` = 11'h100, `trig_req` = 0 and `tmo_req` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| rxd | input | 1 | Serial receive line, idle high |
| rd_en | input | 1 | Data port read strobe; pops one entry |
| trig_sel | input | 3 | Trigger threshold code |
| tmo_sel | input | 2 | Inactivity timeout code |
| rd_word | output | 11 | {break, framing error, empty, byte} of the head entry |
| level | output | 8 | Number of stored entries |
| trig_req | output | 1 | Level at or above threshold |
| tmo_req | output | 1 | Inactivity timeout request |
| overrun | output | 1 | Single-cycle pulse when a byte is dropped |

## Verification
`rd_word`, `trig_req` and `tmo_req` are combinational from the stored state. `level` moves one clock after the stop-bit sample or the read strobe. The stop bit is sampled about half a bit time before the frame ends, so the bench sends each frame for its full ten bit times and samples on a falling edge a few cycles later, when the push is certain to have landed. Timeout checks fall on either side of the limit with margins of about half a character time, which absorbs the sampler's start offset. Single-cycle overrun pulses are counted by a monitor, so their exact edge does not matter.

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int DEPTH     = 64,
  parameter int OSR       = 16,
  parameter int CHAR_BITS = 10,
  parameter int LW        = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          baud_tick,
  input  logic          rxd,
  input  logic          rd_en,
  input  logic [2:0]    trig_sel,
  input  logic [1:0]    tmo_sel,
  output logic [10:0]   rd_word,
  output logic [LW-1:0] level,
  output logic          trig_req,
  output logic          tmo_req,
  output logic          overrun
);
  localparam int AW         = $clog2(DEPTH);
  localparam int CW         = $clog2(DEPTH + 1);
  localparam int PW         = $clog2(OSR);
  localparam int CHAR_TICKS = OSR * CHAR_BITS;
  localparam int TW         = $clog2(CHAR_TICKS);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_STOP, S_HOLD} rx_state_t;

  logic            rx_s1, rx_s2;
  rx_state_t       state;
  logic [PW-1:0]   ph;
  logic [2:0]      bi;
  logic [7:0]      sh;

  wire phase_end = baud_tick && (ph == PW'(OSR - 1));
  wire half_end  = baud_tick && (ph == PW'(OSR / 2 - 1));
  wire push      = (state == S_STOP) && phase_end;
  wire brk_in    = !rx_s2 && (sh == 8'd0);
  wire fe_in     = !rx_s2 && (sh != 8'd0);
  wire rx_busy   = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_s1 <= 1'b1;
      rx_s2 <= 1'b1;
      state <= S_IDLE;
      ph    <= '0;
      bi    <= '0;
      sh    <= '0;
    end else begin
      rx_s1 <= rxd;
      rx_s2 <= rx_s1;
      case (state)
        S_IDLE: if (!rx_s2) begin
          state <= S_START;
          ph    <= '0;
        end
        S_START: if (half_end) begin
          ph    <= '0;
          bi    <= '0;
          state <= rx_s2 ? S_IDLE : S_DATA;
        end else if (baud_tick) ph <= ph + 1'b1;
        S_DATA: if (phase_end) begin
          ph <= '0;
          sh <= {rx_s2, sh[7:1]};
          if (bi == 3'd7) state <= S_STOP;
          bi <= bi + 1'b1;
        end else if (baud_tick) ph <= ph + 1'b1;
        S_STOP: if (phase_end) begin
          ph    <= '0;
          state <= rx_s2 ? S_IDLE : S_HOLD;
        end else if (baud_tick) ph <= ph + 1'b1;
        S_HOLD: if (rx_s2) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  logic [9:0]    mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;

  wire empty = (count == '0);
  wire full  = (count == CW'(DEPTH));
  wire pop   = rd_en && !empty;
  wire wr    = push && (!full || pop);
  assign overrun = push && full && !pop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (wr) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (pop) rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      count <= count + CW'(wr) - CW'(pop);
    end
  end

  always_ff @(posedge clk)
    if (wr) mem[wptr] <= {brk_in, fe_in, sh};

  wire [9:0] head = mem[rptr];
  assign rd_word = empty ? 11'h100 : {head[9:8], 1'b0, head[7:0]};
  assign level   = LW'(count);

  logic [LW-1:0] thr;
  always_comb
    case (trig_sel)
      3'd0:    thr = LW'(1);
      3'd1:    thr = LW'(4);
      3'd2:    thr = LW'(8);
      3'd3:    thr = LW'(16);
      3'd4:    thr = LW'(32);
      default: thr = LW'(48);
    endcase
  assign trig_req = (level >= thr);

  logic [TW-1:0] tcnt;
  logic [4:0]    ccnt;
  logic [4:0]    limit;
  wire restart = push || pop || rx_busy || empty;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      tcnt <= '0;
      ccnt <= '0;
    end else if (baud_tick) begin
      if (tcnt == TW'(CHAR_TICKS - 1)) begin
        tcnt <= '0;
        if (ccnt != 5'd31) ccnt <= ccnt + 1'b1;
      end else tcnt <= tcnt + 1'b1;
    end
  end

  always_comb
    case (tmo_sel)
      2'd1:    limit = 5'd4;
      2'd2:    limit = 5'd8;
      default: limit = 5'd16;
    endcase
  assign tmo_req = (tmo_sel != 2'd0) && !empty && (ccnt >= limit);

  // R5
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));
  // R9
  ovr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> level == LW'(DEPTH));
  // R7
  tmo_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_req |-> level != '0);
  // R8
  tmo_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> !tmo_req);
  // R2
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && level == '0 && !push) |=> level == '0);
endmodule

// File: tb/uart_rx_fifo_test.sv
`timescale 1ns/1ps
module uart_rx_fifo_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic baud_tick = 1'b0;
  logic rxd = 1'b1;
  logic rd_en = 1'b0;
  logic [2:0] trig_sel = 3'd1;
  logic [1:0] tmo_sel = 2'd0;
  logic [10:0] rd_word;
  logic [7:0] level;
  logic trig_req, tmo_req, overrun;

  int vectors = 0;
  int errors = 0;
  int ovr_seen = 0;

  always #2 clk = ~clk;

  uart_rx_fifo uut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rxd(rxd),
    .rd_en(rd_en), .trig_sel(trig_sel), .tmo_sel(tmo_sel),
    .rd_word(rd_word), .level(level), .trig_req(trig_req),
    .tmo_req(tmo_req), .overrun(overrun)
  );

  initial forever begin
    @(negedge clk) baud_tick = 1'b1;
    @(negedge clk) baud_tick = 1'b0;
  end

  always @(negedge clk) if (rst_n && overrun) ovr_seen++;

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; rxd = 1'b1; rd_en = 1'b0;
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(2);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic stop);
    rxd = 1'b0; wait_clk(32);
    for (int i = 0; i < 8; i++) begin rxd = d[i]; wait_clk(32); end
    rxd = stop; wait_clk(32);
    rxd = 1'b1; wait_clk(4);
  endtask

  task automatic read_one(output logic [10:0] w);
    w = rd_word;
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R10 level", level, 0);
    check("R10 rd_word", rd_word, 'h100);
    check("R10 trig_req", trig_req, 0);
    check("R10 tmo_req", tmo_req, 0);
  endtask

  task automatic t_order();
    logic [10:0] w;
    do_reset();
    send_frame(8'hA5, 1'b1);
    send_frame(8'h3C, 1'b1);
    send_frame(8'h01, 1'b1);
    check("R5 level after 3", level, 3);
    read_one(w); check("R1 first", w, 'h0A5);
    check("R5 level after read", level, 2);
    read_one(w); check("R1 second", w, 'h03C);
    read_one(w); check("R1 third", w, 'h001);
    check("R2 empty word", rd_word, 'h100);
    read_one(w); check("R2 empty read word", w, 'h100);
    wait_clk(1);
    check("R2 empty read level", level, 0);
  endtask

  task automatic t_errors();
    logic [10:0] w;
    do_reset();
    send_frame(8'h5A, 1'b0);
    check("R3 fe level", level, 1);
    read_one(w); check("R3 fe word", w, 'h25A);
    rxd = 1'b0; wait_clk(12 * 32);
    rxd = 1'b1; wait_clk(64);
    check("R4 one break entry", level, 1);
    read_one(w); check("R4 break word", w, 'h400);
    send_frame(8'h77, 1'b1);
    read_one(w); check("R4 next byte after break", w, 'h077);
  endtask

  task automatic t_trigger();
    do_reset();
    trig_sel = 3'd2;
    for (int i = 0; i < 7; i++) send_frame(8'(i), 1'b1);
    check("R6 code2 at 7", trig_req, 0);
    send_frame(8'h07, 1'b1);
    check("R6 code2 at 8", trig_req, 1);
    trig_sel = 3'd3; #1 check("R6 code3 at 8", trig_req, 0);
    trig_sel = 3'd1; #1 check("R6 code1 at 8", trig_req, 1);
    trig_sel = 3'd0; #1 check("R6 code0 at 8", trig_req, 1);
    trig_sel = 3'd4; #1 check("R6 code4 at 8", trig_req, 0);
    trig_sel = 3'd1;
  endtask

  task automatic t_timeout();
    logic [10:0] w;
    do_reset();
    tmo_sel = 2'd1;
    send_frame(8'h11, 1'b1);
    wait_clk(1100); check("R7 code1 before", tmo_req, 0);
    wait_clk(200);  check("R7 code1 after", tmo_req, 1);
    send_frame(8'h22, 1'b1);
    check("R8 byte clears", tmo_req, 0);
    wait_clk(1300); check("R7 code1 again", tmo_req, 1);
    read_one(w);
    wait_clk(1);
    check("R8 read clears", tmo_req, 0);
    check("R8 read value", w, 'h011);
    read_one(w);
    wait_clk(1400); check("R7 empty no tmo", tmo_req, 0);
    do_reset();
    tmo_sel = 2'd3;
    send_frame(8'h33, 1'b1);
    wait_clk(4900); check("R7 code3 before", tmo_req, 0);
    wait_clk(300);  check("R7 code3 after", tmo_req, 1);
    do_reset();
    tmo_sel = 2'd0;
    send_frame(8'h44, 1'b1);
    wait_clk(6000); check("R7 code0 disabled", tmo_req, 0);
  endtask

  task automatic t_overrun();
    logic [10:0] w;
    do_reset();
    ovr_seen = 0;
    for (int i = 0; i < 64; i++) send_frame(8'(i + 8'h40), 1'b1);
    check("R5 full level", level, 64);
    check("R9 no early overrun", ovr_seen, 0);
    send_frame(8'hEE, 1'b1);
    check("R9 overrun pulses", ovr_seen, 1);
    check("R9 level kept", level, 64);
    for (int i = 0; i < 64; i++) begin
      read_one(w);
      if (w !== 11'(i + 8'h40)) check("R9 contents kept", w, i + 'h40);
    end
    vectors++;
    check("R9 drained", rd_word, 'h100);
  endtask

  initial begin
    t_reset();
    t_order();
    t_errors();
    t_trigger();
    t_timeout();
    t_overrun();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule